// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the status word of a small 8-bit microcontroller core. Each cycle it is told which kind of ALU operation, if any, is retiring, together with the two operands, the result and the carry-in that the ALU used. From these it produces the carry, nibble carry, zero and overflow flags itself. Software can also write the four arithmetic flags directly. Two sticky power-management flags sit next to them. One records that the core has entered its halted, low-power state. The other records that the watchdog expired.

The operation code is decoded as 0 idle, 1 add, 2 subtract, 3 logic, 4 rotate left through carry and 5 rotate right through carry. Codes 6 and 7 behave as idle. Subtraction computes A + ~B + cin, so a carry-in of 1 means "no borrow pending". In the same way, the carry and nibble-carry outputs of a subtraction mean "no borrow happened". The status word is registered and appears on `status` one clock after the event. An asynchronous active-low reset clears the whole word. The reset is released on a clock edge through a short synchroniser.

Top module: `sflag_status`

## Requirements
- R1: `status` bit 0 is carry, bit 1 nibble carry, bit 2 zero, bit 3 overflow, bit 4 power-down and bit 5 watchdog timeout. Bits 7 and 6 always read 0, and reset clears all eight bits.
- R2: For an add (op 1), the flags computed from A + B + cin appear one cycle later. Carry is the carry out of bit 7 and nibble carry is the carry out of bit 3.
- R3: For a subtract (op 2), carry is 1 exactly when A − B − (1 − cin) does not borrow out of the byte. Nibble carry is 1 exactly when the low nibbles do not borrow under the same rule.
- R4: Zero is loaded from the supplied result (1 when it is 0x00) on add, subtract and logic operations.
- R5: On add and subtract, overflow is 1 exactly when the two's-complement result falls outside −128..127. This is the same as carry into bit 7 differing from carry out of bit 7.
- R6: A logic operation (op 3) changes only the zero flag. Carry, nibble carry and overflow keep their values.
- R7: A rotate-left-through-carry (op 4) loads carry with A bit 7. A rotate-right-through-carry (op 5) loads carry with A bit 0. Nibble carry, zero and overflow keep their values.
- R8: Power-down is set by `halt` and is cleared only by reset.
- R9: Timeout is set by `wdt_tmo` and cleared by `wdt_clr` or `halt`. When `wdt_tmo` arrives in the same cycle as either clearing event, the timeout flag ends up set.
- R10: A software write (`wr_en`) loads `wr_data` bits 3..0 into flags 3..0 and ignores `wr_data` bits 7..4. A write takes priority over an ALU flag update in the same cycle.
- R11: An idle operation code with no write leaves flags 3..0 unchanged, whatever the operand and result inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| alu_op | input | 3 | Kind of operation retiring this cycle |
| opa | input | 8 | First ALU operand |
| opb | input | 8 | Second ALU operand |
| alu_res | input | 8 | Result produced by the ALU |
| alu_cin | input | 1 | Carry-in used by the ALU (1 = no borrow for subtract) |
| wr_en | input | 1 | Software write of the status word |
| wr_data | input | 8 | Write data; bits 3..0 are used |
| halt | input | 1 | Halt instruction executed |
| wdt_clr | input | 1 | Watchdog-clear instruction executed |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| status | output | 8 | Registered status word |

## Verification
Two pairs of functions can fall in the same clock. The first pair is the watchdog time-out against its two clearing events, halt and watchdog-clear. The bench raises `wdt_tmo` in the same cycle as `halt` and, separately, as `wdt_clr`. It expects the timeout bit set and power-down unaffected by the clear. The second pair is a software write against an arithmetic update. The bench issues a write together with an add whose own flags differ from the written value, and expects the written nibble to win. The add and subtract flags are swept over every A, a stride of B values and both carry-ins, and compared with signed and unsigned arithmetic.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned ARITH_W = 4;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_LOGIC = 3'd3,
    OP_RLC   = 3'd4,
    OP_RRC   = 3'd5
  } alu_op_e;

  // Packed so that c lands in bit 0 and ov in bit 3 of the status word.
  typedef struct packed {
    logic ov;
    logic z;
    logic ac;
    logic c;
  } arith_flags_t;

  typedef struct packed {
    logic to;
    logic pd;
  } pm_flags_t;

endpackage

// File: rtl/sflag_rst_sync.sv
module sflag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES:0] link;

  assign link[0] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic q;
    always_ff @(posedge clk or negedge rst_n_in) begin
      if (!rst_n_in) begin
        q <= 1'b0;
      end else begin
        q <= link[i];
      end
    end
    assign link[i+1] = q;
  end

  assign rst_n_out = link[STAGES];

endmodule

// File: rtl/sflag_arith.sv
module sflag_arith
  import sflag_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned NW = 4
) (
  input  alu_op_e        op,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic [DW-1:0]  res,
  input  logic           cin,
  input  arith_flags_t   cur,
  output arith_flags_t   nxt,
  output logic           upd
);

  logic [DW-1:0] b_eff;
  logic [NW:0]   unused_lo_sum;
  logic [DW-1:0] unused_mid_sum;
  logic [DW:0]   unused_full_sum;
  logic          c_nib;
  logic          c_into_msb;
  logic          c_out;
  logic          res_zero;

  always_comb begin
    b_eff           = (op == OP_SUB) ? ~opb : opb;
    unused_lo_sum   = {1'b0, opa[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin};
    unused_mid_sum  = {1'b0, opa[DW-2:0]} + {1'b0, b_eff[DW-2:0]} + {{(DW-1){1'b0}}, cin};
    unused_full_sum = {1'b0, opa} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    c_nib           = unused_lo_sum[NW];
    c_into_msb      = unused_mid_sum[DW-1];
    c_out           = unused_full_sum[DW];
    res_zero        = (res == '0);
  end

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin
        nxt.c  = c_out;
        nxt.ac = c_nib;
        nxt.ov = c_into_msb ^ c_out;
        nxt.z  = res_zero;
        upd    = 1'b1;
      end
      OP_LOGIC: begin
        nxt.z = res_zero;
        upd   = 1'b1;
      end
      OP_RLC: begin
        nxt.c = opa[DW-1];
        upd   = 1'b1;
      end
      OP_RRC: begin
        nxt.c = opa[0];
        upd   = 1'b1;
      end
      default: begin
        nxt = cur;
        upd = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sflag_pm.sv
module sflag_pm
  import sflag_pkg::*;
(
  input  logic      halt,
  input  logic      wdt_clr,
  input  logic      wdt_tmo,
  input  pm_flags_t cur,
  output pm_flags_t nxt,
  output logic      upd
);

  always_comb begin
    nxt = cur;
    if (halt) begin
      nxt.pd = 1'b1;
    end
    if (halt || wdt_clr) begin
      nxt.to = 1'b0;
    end
    // A time-out in the same cycle overrides either clear.
    if (wdt_tmo) begin
      nxt.to = 1'b1;
    end
    upd = halt | wdt_clr | wdt_tmo;
  end

endmodule

// File: rtl/sflag_status.sv
module sflag_status
  import sflag_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned NW          = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    alu_op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] alu_res,
  input  logic          alu_cin,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          halt,
  input  logic          wdt_clr,
  input  logic          wdt_tmo,
  output logic [STAT_W-1:0] status
);

  localparam int unsigned PAD_W = STAT_W - ARITH_W - 2;

  logic         rst_sync_n;
  arith_flags_t arith_q, arith_d, arith_nxt;
  logic         arith_upd, arith_en;
  pm_flags_t    pm_q, pm_nxt;
  logic         pm_upd;
  logic         unused_wr_hi;

  sflag_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  sflag_arith #(.DW(DW), .NW(NW)) u_arith (
    .op  (alu_op_e'(alu_op)),
    .opa (opa),
    .opb (opb),
    .res (alu_res),
    .cin (alu_cin),
    .cur (arith_q),
    .nxt (arith_nxt),
    .upd (arith_upd)
  );

  sflag_pm u_pm (
    .halt    (halt),
    .wdt_clr (wdt_clr),
    .wdt_tmo (wdt_tmo),
    .cur     (pm_q),
    .nxt     (pm_nxt),
    .upd     (pm_upd)
  );

  assign unused_wr_hi = ^wr_data[DW-1:ARITH_W];

  // Next state: a software write outranks the ALU update.
  always_comb begin
    arith_en = wr_en | arith_upd;
    arith_d  = wr_en ? arith_flags_t'(wr_data[ARITH_W-1:0]) : arith_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      arith_q <= '0;
    end else if (arith_en) begin
      arith_q <= arith_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pm_q <= '0;
    end else if (pm_upd) begin
      pm_q <= pm_nxt;
    end
  end

  assign status = {{PAD_W{1'b0}}, pm_q.to, pm_q.pd, arith_q};

endmodule

// File: rtl/sflag_status_chk.sv
module sflag_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] alu_op,
  input logic [7:0] opa,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       halt,
  input logic       wdt_clr,
  input logic       wdt_tmo,
  input logic [7:0] status
);

  assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);

  assert_halt_sets_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> status[4]);

  assert_pd_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] |=> status[4]);

  assert_tmo_sets_to_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tmo |=> status[5]);

  assert_clear_to_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt || wdt_clr) && !wdt_tmo) |=> !status[5]);

  assert_write_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> status[3:0] == $past(wr_data[3:0]));

  assert_logic_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd3 && !wr_en) |=> (status[0] == $past(status[0]) &&
                                    status[1] == $past(status[1]) &&
                                    status[3] == $past(status[3])));

  assert_rlc_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd4 && !wr_en) |=> status[0] == $past(opa[7]));

  assert_rrc_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd5 && !wr_en) |=> status[0] == $past(opa[0]));

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op == 3'd0 && !wr_en) |=> $stable(status[3:0]));

endmodule

bind sflag_status sflag_status_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .alu_op  (alu_op),
  .opa     (opa),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .halt    (halt),
  .wdt_clr (wdt_clr),
  .wdt_tmo (wdt_tmo),
  .status  (status)
);

// File: tb/sflag_status_bench.sv
module sflag_status_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [2:0] alu_op;
  logic [7:0] opa, opb, alu_res, wr_data;
  logic       alu_cin, wr_en, halt, wdt_clr, wdt_tmo;
  logic [7:0] status;

  int n_run  = 0;
  int n_fail = 0;

  sflag_status u_sflag_status (
    .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .opa(opa), .opb(opb),
    .alu_res(alu_res), .alu_cin(alu_cin), .wr_en(wr_en), .wr_data(wr_data),
    .halt(halt), .wdt_clr(wdt_clr), .wdt_tmo(wdt_tmo), .status(status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle();
    alu_op = 3'd0; opa = '0; opb = '0; alu_res = '0; alu_cin = 1'b0;
    wr_en = 1'b0; wr_data = '0; halt = 1'b0; wdt_clr = 1'b0; wdt_tmo = 1'b0;
  endtask

  // Drive one cycle of stimulus, return the status seen after the next edge.
  task automatic step(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] r, input logic ci, input logic we,
                      input logic [7:0] wd, input logic h, input logic cl,
                      input logic tm, output logic [7:0] got);
    @(negedge clk);
    alu_op = op; opa = a; opb = b; alu_res = r; alu_cin = ci;
    wr_en = we; wr_data = wd; halt = h; wdt_clr = cl; wdt_tmo = tm;
    @(negedge clk);
    got = status;
    idle();
  endtask

  task automatic wr(input logic [7:0] d);
    logic [7:0] g;
    step(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, d, 1'b0, 1'b0, 1'b0, g);
  endtask

  initial begin
    logic [7:0] g;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", status, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", status, 8'h00);

    // R2 R3 R4 R5 sweep
    for (int op = 1; op <= 2; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 7) begin
          for (int ci = 0; ci < 2; ci++) begin
            int r, c, ac, ov, sa, sb, sr;
            sa = (a > 127) ? a - 256 : a;
            sb = (b > 127) ? b - 256 : b;
            if (op == 1) begin
              r  = a + b + ci;
              c  = (r > 255) ? 1 : 0;
              ac = ((a % 16) + (b % 16) + ci > 15) ? 1 : 0;
              sr = sa + sb + ci;
            end else begin
              r  = a - b - (1 - ci);
              c  = (r >= 0) ? 1 : 0;
              ac = ((a % 16) - (b % 16) - (1 - ci) >= 0) ? 1 : 0;
              sr = sa - sb - (1 - ci);
            end
            ov = (sr > 127 || sr < -128) ? 1 : 0;
            r  = r & 255;
            step(3'(op), 8'(a), 8'(b), 8'(r), 1'(ci), 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, g);
            chk((op == 1) ? "R2 R4 R5 add" : "R3 R4 R5 sub", g,
                {4'h0, 1'(ov), (r == 0) ? 1'b1 : 1'b0, 1'(ac), 1'(c)});
          end
        end
      end
    end

    // R6 logic leaves C, AC, OV
    wr(8'h0F);
    step(3'd3, 8'hAA, 8'h55, 8'h55, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, g);
    chk("R6 logic nonzero", g, 8'h0B);
    step(3'd3, 8'hAA, 8'h55, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, g);
    chk("R6 R4 logic zero", g, 8'h0F);
    wr(8'h00);
    step(3'd3, 8'hFF, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, g);
    chk("R6 logic from clear", g, 8'h04);

    // R7 rotates, all A values
    wr(8'h0A);
    for (int a = 0; a < 256; a++) begin
      step(3'd4, 8'(a), 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, g);
      chk("R7 rlc", g, {7'b0000101, 1'((a >> 7) & 1)});
      step(3'd5, 8'(a), 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, g);
      chk("R7 rrc", g, {7'b0000101, 1'(a & 1)});
    end

    // R10 writes
    wr(8'hF5);
    chk("R10 high bits ignored", status, 8'h05);
    step(3'd1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0, g);
    chk("R10 write beats add", g, 8'h03);

    // R11 idle with busy inputs, including unused codes 6 and 7
    wr(8'h09);
    step(3'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, g);
    chk("R11 idle", g, 8'h09);
    step(3'd6, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, g);
    chk("R11 code 6", g, 8'h09);
    step(3'd7, 8'h80, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, g);
    chk("R11 code 7", g, 8'h09);

    // R8 R9 power management
    step(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, g);
    chk("R9 timeout sets", g, 8'h29);
    step(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, g);
    chk("R9 clear instr", g, 8'h09);
    step(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, g);
    chk("R9 timeout again", g, 8'h29);
    step(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, g);
    chk("R8 R9 halt", g, 8'h19);
    wr(8'h00);
    chk("R8 R10 write cannot clear pd", status, 8'h10);
    step(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, g);
    chk("R9 halt with timeout", g, 8'h30);
    step(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, g);
    chk("R9 clear keeps pd", g, 8'h10);
    step(3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, g);
    chk("R9 clear with timeout", g, 8'h30);
    step(3'd1, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, g);
    chk("R8 R5 halt with add", g, 8'h1A);

    // R1 reset clears everything again
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", status, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 R8 pd cleared by reset", status, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule